// File: doc/BRIEF.md
# Frame-Buffer Pixel Unpacker with Colour Lookup

This block sits between a frame-buffer fetch engine and a display timing generator. It accepts 32-bit words on a valid/ready input. Each word is split into pixels, and the block emits one 24-bit RGB value for each pixel-clock enable. In 16-bit mode a word holds two pixels, and each pixel is widened from a 5:6:5 or 5:5:5:1 layout onto three 8-bit colour lanes. In 8-bit mode a word holds four indices. Each index selects a 16-bit colour from a 256-entry lookup RAM, and that colour is widened the same way. Two swap controls set the order in which halfwords and bytes leave the word.

The control is a two-state machine. In `ST_IDLE` the input is ready. When a word is offered, the transition `accept` stores the word and its configuration and moves to `ST_EMIT`. In `ST_EMIT` each pixel-clock enable emits one pixel. The transition `drain`, taken on the enable that emits the final pixel of the word, returns to `ST_IDLE`. A software-written override colour, when enabled, replaces every emitted pixel.

Top module: `pix_unpack`

## Requirements
- R1: After reset, and whenever no word is being emitted, `in_ready` is 1. From the cycle after a word is accepted until the cycle after its final pixel is emitted, `in_ready` is 0.
- R2: In 16-bit mode (`mode_8bpp`=0) each word gives exactly two pixels. With both swap inputs at 0, bits [31:16] are emitted first and bits [15:0] second.
- R3: With `swap_half`=1, bits [15:0] of the word are emitted before bits [31:16]. This applies to both modes.
- R4: With `swap_byte`=1, the two bytes inside each halfword are exchanged. In 16-bit mode the pixel value becomes {h[7:0],h[15:8]}. In 8-bit mode the low byte of each halfword is emitted before its high byte.
- R5: With `fmt_5551`=0 a 16-bit colour c is output as {c[15:11],3'b0, c[10:5],2'b0, c[4:0],3'b0}.
- R6: With `fmt_5551`=1 a 16-bit colour c is output as {c[15:11],c[0],2'b0, c[10:6],c[0],2'b0, c[5:1],c[0],2'b0}. The intensity bit c[0] is placed directly below the five colour bits of each lane, at bits 18, 10 and 2.
- R7: In 8-bit mode each word gives four pixels. With both swap inputs at 0 the bytes are emitted from [31:24] down to [7:0]. Each byte is an index into the lookup RAM, and the colour stored there is widened per R5/R6.
- R8: A cycle with `pal_we`=1 stores `pal_wdata[15:0]` at entry `pal_addr`. Bits [31:16] of the write are discarded.
- R9: When `tmp_en` is 1 at the enable that emits a pixel, that pixel's output is `tmp_color` instead of the frame data.
- R10: A pixel is emitted only on a cycle with `pix_en`=1 while a word is held. `pix_valid` is 1 for exactly one cycle after each such edge and 0 at all other times.
- R11: The inputs `mode_8bpp`, `swap_half`, `swap_byte` and `fmt_5551` are sampled when a word is accepted. Changing them while that word is being emitted has no effect on its pixels.
- R12: During and after reset `pix_valid` is 0 and `pix_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel per asserted cycle |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Frame-buffer word |
| mode_8bpp | input | 1 | 1: four palette indices per word; 0: two 16-bit pixels |
| swap_half | input | 1 | Emit the lower halfword first |
| swap_byte | input | 1 | Exchange bytes within each halfword |
| fmt_5551 | input | 1 | 1: 5:5:5:1 layout; 0: 5:6:5 layout |
| tmp_en | input | 1 | Override every output pixel |
| tmp_color | input | 24 | Override colour |
| pal_we | input | 1 | Lookup RAM write strobe |
| pal_addr | input | 8 | Lookup RAM write entry |
| pal_wdata | input | 32 | Lookup RAM write data; low 16 bits kept |
| pix_valid | output | 1 | Output pixel valid for one cycle |
| pix_data | output | 24 | RGB output {R[7:0],G[7:0],B[7:0]} |

## Verification
Take a word accepted on edge E0 with `pix_en` held high. Its first pixel is registered on E1 and its second on E2, and in 8-bit mode the later pixels follow on E3 and E4. Each pixel is therefore visible one cycle after the enable edge that emitted it. `in_ready` returns in the cycle after the final pixel. The bench drives all inputs at the falling edge and samples there too, so each expected value is compared in the half-cycle that follows the edge producing it. A falling-edge monitor records every cycle with `pix_valid` high. Ordering and colour checks compare against that record, and the ready and stall checks instead look at the exact falling edge after each counted rising edge.

// File: rtl/pu_pkg.sv
`timescale 1ns/1ps
package pu_pkg;
    localparam int WORD_W = 32;
    localparam int PIX_W  = 16;
    localparam int IDX_W  = 8;
    localparam int LANE_W = 8;
    localparam int OUT_W  = 3 * LANE_W;
    localparam int PER_WORD_16 = WORD_W / PIX_W;
    localparam int PER_WORD_8  = WORD_W / IDX_W;
    localparam int CNT_W  = $clog2(PER_WORD_8);
    localparam int PAL_DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic mode8;
        logic swap_half;
        logic swap_byte;
        logic fmt_5551;
    } pu_cfg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } pu_state_t;
endpackage

// File: rtl/pu_select.sv
`timescale 1ns/1ps
module pu_select
    import pu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  slot,
    input  pu_cfg_t           cfg,
    output logic [PIX_W-1:0]  pix16,
    output logic [IDX_W-1:0]  idx
);
    logic             half_no;
    logic [PIX_W-1:0] half;

    always_comb begin
        half_no = cfg.mode8 ? slot[1] : slot[0];
        half    = (half_no ^ cfg.swap_half) ? word[PIX_W-1:0] : word[WORD_W-1:PIX_W];
        pix16   = cfg.swap_byte ? {half[IDX_W-1:0], half[PIX_W-1:IDX_W]} : half;
        idx     = (slot[0] ^ cfg.swap_byte) ? half[IDX_W-1:0] : half[PIX_W-1:IDX_W];
    end
endmodule

// File: rtl/pu_expand.sv
`timescale 1ns/1ps
module pu_expand
    import pu_pkg::*;
(
    input  logic [PIX_W-1:0] colour,
    input  logic             fmt_5551,
    output logic [OUT_W-1:0] rgb
);
    logic i_bit;

    always_comb begin
        i_bit = colour[0];
        if (fmt_5551) begin
            rgb = {colour[15:11], i_bit, {(LANE_W-6){1'b0}},
                   colour[10:6],  i_bit, {(LANE_W-6){1'b0}},
                   colour[5:1],   i_bit, {(LANE_W-6){1'b0}}};
        end else begin
            rgb = {colour[15:11], {(LANE_W-5){1'b0}},
                   colour[10:5],  {(LANE_W-6){1'b0}},
                   colour[4:0],   {(LANE_W-5){1'b0}}};
        end
    end
endmodule

// File: rtl/pu_palette.sv
`timescale 1ns/1ps
module pu_palette
    import pu_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [PIX_W-1:0] rdata
);
    logic [PIX_W-1:0] mem [PAL_DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pix_unpack.sv
`timescale 1ns/1ps
module pix_unpack
    import pu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              mode_8bpp,
    input  logic              swap_half,
    input  logic              swap_byte,
    input  logic              fmt_5551,
    input  logic              tmp_en,
    input  logic [OUT_W-1:0]  tmp_color,
    input  logic              pal_we,
    input  logic [IDX_W-1:0]  pal_addr,
    input  logic [WORD_W-1:0] pal_wdata,
    output logic              pix_valid,
    output logic [OUT_W-1:0]  pix_data
);
    localparam logic [CNT_W-1:0] LAST_16 = CNT_W'(PER_WORD_16 - 1);
    localparam logic [CNT_W-1:0] LAST_8  = CNT_W'(PER_WORD_8 - 1);

    pu_state_t         state_q, state_d;
    pu_cfg_t           cfg_q;
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  slot_q;
    logic              accept, emit, last_slot;
    logic [PIX_W-1:0]  pix16, pal_colour, colour;
    logic [IDX_W-1:0]  idx;
    logic [OUT_W-1:0]  rgb;
    logic              pal_hi_unused;

    assign pal_hi_unused = ^pal_wdata[WORD_W-1:PIX_W];

    assign in_ready  = (state_q == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign emit      = (state_q == ST_EMIT) && pix_en;
    assign last_slot = (slot_q == (cfg_q.mode8 ? LAST_8 : LAST_16));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)          state_d = ST_EMIT;  // accept
            ST_EMIT: if (pix_en && last_slot) state_d = ST_IDLE; // drain
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    pu_select u_sel (
        .word  (word_q),
        .slot  (slot_q),
        .cfg   (cfg_q),
        .pix16 (pix16),
        .idx   (idx)
    );

    pu_palette u_pal (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_addr),
        .wdata (pal_wdata[PIX_W-1:0]),
        .raddr (idx),
        .rdata (pal_colour)
    );

    assign colour = cfg_q.mode8 ? pal_colour : pix16;

    pu_expand u_exp (
        .colour   (colour),
        .fmt_5551 (cfg_q.fmt_5551),
        .rgb      (rgb)
    );

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            cfg_q     <= '0;
            slot_q    <= '0;
            pix_valid <= 1'b0;
            pix_data  <= '0;
        end else begin
            pix_valid <= 1'b0;
            if (accept) begin
                word_q <= in_word;
                cfg_q  <= '{mode8: mode_8bpp, swap_half: swap_half,
                            swap_byte: swap_byte, fmt_5551: fmt_5551};
                slot_q <= '0;
            end else if (emit) begin
                pix_valid <= 1'b1;
                pix_data  <= tmp_en ? tmp_color : rgb;
                slot_q    <= slot_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pu_checker.sv
`timescale 1ns/1ps
module pu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_en,
    input logic        in_valid,
    input logic        in_ready,
    input logic        mode_8bpp,
    input logic        fmt_5551,
    input logic        tmp_en,
    input logic [23:0] tmp_color,
    input logic        pix_valid,
    input logic [23:0] pix_data
);
    int   seen;
    logic had_word, m8_q, f5551_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 0; had_word <= 1'b0; m8_q <= 1'b0; f5551_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            seen <= 0; had_word <= 1'b1; m8_q <= mode_8bpp; f5551_q <= fmt_5551;
        end else if (pix_valid) begin
            seen <= seen + 1;
        end
    end

    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_pixels_per_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && had_word) |->
        ((seen + (pix_valid ? 1 : 0)) == (m8_q ? 4 : 2)));

    p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !$past(tmp_en) && !f5551_q) |->
        (pix_data[18:16] == 3'b0 && pix_data[9:8] == 2'b0 && pix_data[2:0] == 3'b0));

    p_intensity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !$past(tmp_en) && f5551_q) |->
        (pix_data[17:16] == 2'b0 && pix_data[9:8] == 2'b0 && pix_data[1:0] == 2'b0 &&
         pix_data[18] == pix_data[10] && pix_data[10] == pix_data[2]));

    p_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(tmp_en)) |-> (pix_data == $past(tmp_color)));

    p_enable_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(pix_en));
endmodule

bind pix_unpack pu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mode_8bpp (mode_8bpp),
    .fmt_5551  (fmt_5551),
    .tmp_en    (tmp_en),
    .tmp_color (tmp_color),
    .pix_valid (pix_valid),
    .pix_data  (pix_data)
);

// File: tb/sim_pix_unpack.sv
`timescale 1ns/1ps
module sim_pix_unpack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0, in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        mode_8bpp = 1'b0, swap_half = 1'b0, swap_byte = 1'b0, fmt_5551 = 1'b0;
    logic        tmp_en = 1'b0;
    logic [23:0] tmp_color = '0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_addr = '0;
    logic [31:0] pal_wdata = '0;
    logic        pix_valid;
    logic [23:0] pix_data;

    int nchk = 0, nfail = 0, ng = 0;
    logic [23:0] got [0:15];
    logic [15:0] pal_model [0:255];

    always #2 clk = ~clk;

    pix_unpack u0 (.*);

    always @(negedge clk) begin
        if (pix_valid && ng < 16) begin
            got[ng] = pix_data;
            ng = ng + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] widen(input logic [15:0] c, input logic f);
        if (f) widen = {c[15:11], c[0], 2'b00, c[10:6], c[0], 2'b00, c[5:1], c[0], 2'b00};
        else   widen = {c[15:11], 3'b000, c[10:5], 2'b00, c[4:0], 3'b000};
    endfunction

    // halfword k (0 = first emitted)
    function automatic logic [15:0] half_at(input logic [31:0] w, input int k, input logic sh);
        if ((k == 0) != sh) half_at = w[31:16];
        else                half_at = w[15:0];
    endfunction

    function automatic logic [23:0] exp16(input logic [31:0] w, input int k,
                                          input logic sh, input logic sb, input logic f);
        logic [15:0] h;
        h = half_at(w, k, sh);
        if (sb) h = {h[7:0], h[15:8]};
        exp16 = widen(h, f);
    endfunction

    function automatic logic [23:0] exp8(input logic [31:0] w, input int k,
                                         input logic sh, input logic sb, input logic f);
        logic [15:0] h;
        logic [7:0]  b;
        h = half_at(w, k / 2, sh);
        b = (((k % 2) == 0) != sb) ? h[15:8] : h[7:0];
        exp8 = widen(pal_model[b], f);
    endfunction

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_pix(input int n, input string req);
        int t = 0;
        while (ng < n && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk(req, ng, n);
    endtask

    task automatic set_cfg(input logic m8, input logic sh, input logic sb, input logic f);
        mode_8bpp = m8; swap_half = sh; swap_byte = sb; fmt_5551 = f;
    endtask

    task automatic wr_pal(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        pal_we = 1'b1; pal_addr = a; pal_wdata = d;
        pal_model[a] = d[15:0];
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 pix_valid", pix_valid, 0);
        chk("R12 pix_data", pix_data, 0);
        chk("R1 ready after reset", in_ready, 1);
    endtask

    task automatic t_word16(input logic [31:0] w, input logic sh, input logic sb,
                            input logic f, input string req);
        set_cfg(1'b0, sh, sb, f);
        pix_en = 1'b1;
        ng = 0;
        send(w);
        wait_pix(2, {req, " R2 count"});
        repeat (3) @(negedge clk);
        chk({req, " R2 no extra pixel"}, ng, 2);
        for (int k = 0; k < 2; k++) chk({req, " pixel"}, got[k], exp16(w, k, sh, sb, f));
    endtask

    task automatic t_word8(input logic [31:0] w, input logic sh, input logic sb,
                           input logic f, input string req);
        set_cfg(1'b1, sh, sb, f);
        pix_en = 1'b1;
        ng = 0;
        send(w);
        wait_pix(4, {req, " R7 count"});
        for (int k = 0; k < 4; k++) chk({req, " index pixel"}, got[k], exp8(w, k, sh, sb, f));
    endtask

    task automatic t_ready;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        pix_en = 1'b1;
        ng = 0;
        send(32'hF800_07E0);
        chk("R1 low after accept", in_ready, 0);
        @(negedge clk);
        chk("R1 low after first pixel", in_ready, 0);
        chk("R10 first pixel valid", pix_valid, 1);
        @(negedge clk);
        chk("R1 high after last pixel", in_ready, 1);
        chk("R10 last pixel valid", pix_valid, 1);
        @(negedge clk);
        chk("R10 valid drops", pix_valid, 0);
    endtask

    task automatic t_stall;
        logic [31:0] w = 32'h1234_ABCD;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
        pix_en = 1'b0;
        ng = 0;
        send(w);
        for (int i = 0; i < 5; i++) begin
            chk("R10 no pixel while disabled", pix_valid, 0);
            @(negedge clk);
        end
        chk("R10 nothing emitted", ng, 0);
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
        chk("R10 single enable gives pixel", pix_valid, 1);
        chk("R6 stalled pixel0", pix_data, exp16(w, 0, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        chk("R10 valid one cycle", pix_valid, 0);
        chk("R1 still busy", in_ready, 0);
        pix_en = 1'b1;
        wait_pix(2, "R10 resume");
        chk("R6 stalled pixel1", got[1], exp16(w, 1, 1'b0, 1'b0, 1'b1));
    endtask

    task automatic t_override;
        tmp_color = 24'hA5_5A_C3;
        tmp_en = 1'b1;
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
        pix_en = 1'b1;
        ng = 0;
        send(32'h0102_0304);
        wait_pix(4, "R9 count");
        for (int k = 0; k < 4; k++) chk("R9 override colour", got[k], 24'hA5_5A_C3);
        tmp_en = 1'b0;
    endtask

    task automatic t_cfg_hold;
        logic [31:0] w = 32'hC3A5_5A3C;
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
        pix_en = 1'b1;
        ng = 0;
        send(w);
        set_cfg(1'b1, 1'b1, 1'b1, 1'b1);
        wait_pix(2, "R11 count");
        repeat (3) @(negedge clk);
        chk("R11 still two pixels", ng, 2);
        for (int k = 0; k < 2; k++) chk("R11 config held", got[k], exp16(w, k, 1'b0, 1'b0, 1'b0));
    endtask

    initial begin
        #10000000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ready();
        t_word16(32'hF81F_07E0, 1'b0, 1'b0, 1'b0, "R2 R5 plain order");
        t_word16(32'h1234_8001, 1'b1, 1'b0, 1'b0, "R3 half swap");
        t_word16(32'h1234_ABCD, 1'b0, 1'b1, 1'b0, "R4 byte swap");
        t_word16(32'hFFFF_0001, 1'b1, 1'b1, 1'b1, "R6 both swaps 5551");
        t_word16(32'h7BCE_8421, 1'b0, 1'b0, 1'b1, "R6 intensity mix");
        for (int i = 0; i < 8; i++)
            wr_pal(8'(i * 37 + 5), {16'hDEAD, 16'(i * 16'h1357 + 16'h0841)});
        wr_pal(8'h00, 32'hFFFF_F801);
        wr_pal(8'hFF, 32'h1234_07FE);
        t_word8({8'd5, 8'd42, 8'd79, 8'd116}, 1'b0, 1'b0, 1'b0, "R7 R8 index order");
        t_word8({8'd153, 8'd190, 8'd227, 8'd08}, 1'b1, 1'b0, 1'b1, "R3 R7 half swap 8bit");
        t_word8({8'h00, 8'hFF, 8'd5, 8'd42}, 1'b0, 1'b1, 1'b0, "R4 R8 byte swap 8bit");
        t_word8({8'hFF, 8'h00, 8'd79, 8'hFF}, 1'b1, 1'b1, 1'b1, "R6 R7 both swaps 8bit");
        t_stall();
        t_override();
        t_cfg_hold();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule